// File: doc/BRIEF.md
# X9.17-style random value sequencer

This block produces 64-bit pseudo-random values by chaining three encryptions through one external block-cipher unit. Before any value can be drawn, a secret starting seed is written into an internal seed register. Each accepted generate request then samples a timestamp and runs three cipher calls, one after the other. The first call encrypts the timestamp and keeps the result as a scratch value. The second encrypts that scratch value XOR the seed, and its result is the random output. The third encrypts the scratch value XOR the output, and its result becomes the next seed.

The cipher sits outside the block and is reached through a start/done handshake. The block pulses a start strobe with the operand on a data bus, then waits for a one-cycle done strobe that comes with the result. The three internal words are written only on the edge that takes in a cipher result, or on a seed write, so they stay still while the cipher is working. A valid strobe marks the output on the edge where the seed is updated. That means a request accepted right afterwards always sees the new seed.

Top module: `x917_prng_seq`

## Requirements
- R1: After a synchronous reset, `rnd_valid` and `ciph_start` are low and no seed is held.
- R2: While no seed has been written since reset, `gen_req` starts no cipher call and produces no output.
- R3: `seed_load` in the idle state copies `seed_in` into the seed register. If `seed_load` and `gen_req` arrive in the same idle cycle, the seed write wins and the generate request is dropped.
- R4: An accepted request samples `tstamp` at its accept edge. The first cipher operand is that timestamp, and the result is kept as the scratch value S.
- R5: The second operand is S XOR seed. Its result is kept as R and is the value shown on `rnd_out`.
- R6: The third operand is S XOR R, and its result replaces the seed.
- R7: Every call begins with a `ciph_start` pulse of exactly one cycle. The first pulse comes one cycle after the accept edge. Each later pulse comes two cycles after the edge that takes in the previous `ciph_done`. `ciph_din` holds steady while a call is outstanding.
- R8: S, R and the seed do not change while a call is outstanding. They change only on the edge that takes in `ciph_done`.
- R9: `rnd_valid` is a one-cycle pulse raised by the edge that takes in the third result. No other cycle raises it.
- R10: `gen_req` and `seed_load` seen while a sequence is running are ignored.
- R11: A `ciph_done` pulse while no call is outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Write strobe for the seed |
| seed_in | input | 64 | Seed value to write |
| gen_req | input | 1 | Request strobe for one random value |
| tstamp | input | 64 | Timestamp sampled when a request is accepted |
| ciph_start | output | 1 | One-cycle strobe launching a cipher call |
| ciph_din | output | 64 | Operand for the cipher call |
| ciph_done | input | 1 | One-cycle strobe marking the cipher result |
| ciph_dout | input | 64 | Cipher result, valid with `ciph_done` |
| rnd_valid | output | 1 | One-cycle strobe marking a new random value |
| rnd_out | output | 64 | Most recent random value |

## Verification
The assertions assume the cipher keeps to its side of the handshake. It answers each start strobe with exactly one `ciph_done` pulse, at least one cycle later. It raises no done while a call is in flight unless that done belongs to the call. The bench's cipher model answers each start after a programmable delay of one or more cycles. It injects a stray done only while the sequencer is idle, and never during a call. Request and seed strobes are driven freely, including during running sequences and in the same cycle as each other.

// File: rtl/x917_pkg.sv
package x917_pkg;
  localparam int NSLOT  = 3;
  localparam int SLOT_S = 0;
  localparam int SLOT_R = 1;
  localparam int SLOT_V = 2;
  localparam int STEPW  = $clog2(NSLOT);

  typedef logic [STEPW-1:0] step_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_NEXT = 2'd2
  } phase_t;
endpackage

// File: rtl/x917_ctrl.sv
module x917_ctrl
  import x917_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_load,
  input  logic             gen_req,
  input  logic             ciph_done,
  output logic             launch,
  output logic             load_v,
  output step_t            step,
  output logic [NSLOT-1:0] wr,
  output logic             waiting,
  output logic             seeded,
  output logic             start_q,
  output logic             valid_q
);
  phase_t phase;
  logic   take;

  always_comb begin
    load_v  = (phase == PH_IDLE) && seed_load;
    launch  = ((phase == PH_IDLE) && gen_req && seeded && !seed_load) ||
              (phase == PH_NEXT);
    waiting = (phase == PH_WAIT);
    take    = waiting && ciph_done;
    wr      = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (take && (step == step_t'(i))) wr[i] = 1'b1;
    end
    if (load_v) wr[SLOT_V] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      step    <= '0;
      seeded  <= 1'b0;
      start_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      start_q <= launch;
      valid_q <= take && (step == step_t'(NSLOT-1));
      if (load_v) seeded <= 1'b1;
      unique case (phase)
        PH_IDLE: begin
          if (launch) begin
            phase <= PH_WAIT;
            step  <= '0;
          end
        end
        PH_WAIT: begin
          if (ciph_done) begin
            if (step == step_t'(NSLOT-1)) begin
              phase <= PH_IDLE;
              step  <= '0;
            end else begin
              phase <= PH_NEXT;
              step  <= step + step_t'(1);
            end
          end
        end
        PH_NEXT: phase <= PH_WAIT;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/x917_slots.sv
module x917_slots
  import x917_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSLOT-1:0]        wr,
  input  logic                    load_v,
  input  logic [W-1:0]            seed,
  input  logic [W-1:0]            dout,
  output logic [NSLOT-1:0][W-1:0] q
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [W-1:0] nxt;
    if (g == SLOT_V) begin : g_seedmux
      assign nxt = load_v ? seed : dout;
    end else begin : g_plain
      assign nxt = dout;
    end
    always_ff @(posedge clk) begin
      if (rst)        q[g] <= '0;
      else if (wr[g]) q[g] <= nxt;
    end
  end
endmodule

// File: rtl/x917_feed.sv
module x917_feed
  import x917_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         launch,
  input  step_t        step,
  input  logic [W-1:0] tstamp,
  input  logic [W-1:0] s_val,
  input  logic [W-1:0] r_val,
  input  logic [W-1:0] v_val,
  output logic [W-1:0] din_q
);
  logic [W-1:0] operand;

  always_comb begin
    unique case (step)
      step_t'(0): operand = tstamp;
      step_t'(1): operand = s_val ^ v_val;
      default:    operand = s_val ^ r_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         din_q <= '0;
    else if (launch) din_q <= operand;
  end
endmodule

// File: rtl/x917_prng_seq.sv
module x917_prng_seq
  import x917_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_load,
  input  logic [W-1:0] seed_in,
  input  logic         gen_req,
  input  logic [W-1:0] tstamp,
  output logic         ciph_start,
  output logic [W-1:0] ciph_din,
  input  logic         ciph_done,
  input  logic [W-1:0] ciph_dout,
  output logic         rnd_valid,
  output logic [W-1:0] rnd_out
);
  logic                    launch;
  logic                    load_v;
  step_t                   step;
  logic [NSLOT-1:0]        wr;
  logic                    waiting;
  logic                    seeded;
  logic [NSLOT-1:0][W-1:0] slot_q;
  logic [W-1:0]            s_q;
  logic [W-1:0]            r_q;
  logic [W-1:0]            v_q;

  x917_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .seed_load(seed_load),
    .gen_req  (gen_req),
    .ciph_done(ciph_done),
    .launch   (launch),
    .load_v   (load_v),
    .step     (step),
    .wr       (wr),
    .waiting  (waiting),
    .seeded   (seeded),
    .start_q  (ciph_start),
    .valid_q  (rnd_valid)
  );

  x917_slots #(.W(W)) u_slots (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr),
    .load_v(load_v),
    .seed  (seed_in),
    .dout  (ciph_dout),
    .q     (slot_q)
  );

  assign s_q = slot_q[SLOT_S];
  assign r_q = slot_q[SLOT_R];
  assign v_q = slot_q[SLOT_V];

  x917_feed #(.W(W)) u_feed (
    .clk   (clk),
    .rst   (rst),
    .launch(launch),
    .step  (step),
    .tstamp(tstamp),
    .s_val (s_q),
    .r_val (r_q),
    .v_val (v_q),
    .din_q (ciph_din)
  );

  assign rnd_out = r_q;
endmodule

// File: rtl/x917_prng_chk.sv
module x917_prng_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         ciph_start,
  input logic [W-1:0] ciph_din,
  input logic         ciph_done,
  input logic [W-1:0] ciph_dout,
  input logic         rnd_valid,
  input logic         waiting,
  input logic         seeded,
  input logic [W-1:0] s_q,
  input logic [W-1:0] r_q,
  input logic [W-1:0] v_q
);
  p_no_start_unseeded_r2: assert property (@(posedge clk) disable iff (rst)
    !seeded |-> !ciph_start);

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ciph_start |=> !ciph_start);

  p_start_in_wait_r7: assert property (@(posedge clk) disable iff (rst)
    ciph_start |-> waiting);

  p_din_steady_r7: assert property (@(posedge clk) disable iff (rst)
    waiting |=> $stable(ciph_din));

  p_words_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (waiting && !ciph_done) |=> ($stable(s_q) && $stable(r_q) && $stable(v_q)));

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |=> !rnd_valid);

  p_valid_follows_done_r9: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |-> $past(ciph_done));

  p_seed_from_third_r6: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |-> (v_q == $past(ciph_dout)));
endmodule

bind x917_prng_seq x917_prng_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ciph_start(ciph_start),
  .ciph_din  (ciph_din),
  .ciph_done (ciph_done),
  .ciph_dout (ciph_dout),
  .rnd_valid (rnd_valid),
  .waiting   (waiting),
  .seeded    (seeded),
  .s_q       (s_q),
  .r_q       (r_q),
  .v_q       (v_q)
);

// File: tb/x917_prng_seq_tb.sv
module x917_prng_seq_tb;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         seed_load = 1'b0;
  logic         gen_req = 1'b0;
  logic         ciph_done = 1'b0;
  logic [W-1:0] seed_in = '0;
  logic [W-1:0] tstamp = '0;
  logic [W-1:0] ciph_dout = '0;
  logic         ciph_start;
  logic         rnd_valid;
  logic [W-1:0] ciph_din;
  logic [W-1:0] rnd_out;

  always #5 clk = ~clk;

  x917_prng_seq #(.W(W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .seed_load (seed_load),
    .seed_in   (seed_in),
    .gen_req   (gen_req),
    .tstamp    (tstamp),
    .ciph_start(ciph_start),
    .ciph_din  (ciph_din),
    .ciph_done (ciph_done),
    .ciph_dout (ciph_dout),
    .rnd_valid (rnd_valid),
    .rnd_out   (rnd_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 0;
  int cyc = 0;

  // reference model state
  bit           ref_seeded = 0;
  bit           ref_busy = 0;
  logic [W-1:0] ref_t = '0, ref_s = '0, ref_r = '0, ref_v = '0, exp_in = '0;
  int           call_idx = 0;
  int           cnt = 0;
  int           lat = 1;
  bit           due1 = 0, due2 = 0, valid_due = 0, spur = 0;
  int           starts_seen = 0;
  int           valids_seen = 0;

  function automatic logic [W-1:0] enc(input logic [W-1:0] x);
    return ({x[W-2:0], x[W-1]} ^ 64'hA5C3_0F1E_9B27_D468) + 64'h0123_4567_89AB_CDEF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Cycle-by-cycle model: cipher stand-in plus expected behaviour, at negedge
  always @(negedge clk) begin : mdl
    bit acc, ld, dn;
    if (rst) begin
      ref_seeded = 0; ref_busy = 0; cnt = 0; call_idx = 0;
      due1 = 0; due2 = 0; valid_due = 0; ciph_done = 0;
    end else begin
      acc = gen_req && ref_seeded && !ref_busy && !seed_load;
      ld  = seed_load && !ref_busy;
      if (ld) begin ref_v = seed_in; ref_seeded = 1; end
      if (acc) begin ref_busy = 1; ref_t = tstamp; call_idx = 0; end

      chk(rnd_valid == valid_due, "R9 valid strobe timing", W'(rnd_valid), W'(valid_due));
      if (rnd_valid) begin
        valids_seen++;
        chk(rnd_out == ref_r, "R5 R8 output value", rnd_out, ref_r);
      end
      if (valid_due) ref_busy = 0;
      valid_due = 0;

      dn = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          dn = 1;
          ciph_dout = enc(exp_in);
          case (call_idx)
            0: ref_s = ciph_dout;
            1: ref_r = ciph_dout;
            default: begin ref_v = ciph_dout; valid_due = 1; end
          endcase
          call_idx++;
        end
      end
      ciph_done = dn || spur;
      if (spur && !dn) ciph_dout = 64'h5A5A_F00D_0BAD_C0DE;

      chk(ciph_start == (acc || due2), "R7 start strobe timing",
          W'(ciph_start), W'(acc || due2));
      if (ciph_start) begin
        starts_seen++;
        case (call_idx)
          0: begin exp_in = ref_t;         chk(ciph_din == exp_in, "R4 first operand", ciph_din, exp_in); end
          1: begin exp_in = ref_s ^ ref_v; chk(ciph_din == exp_in, "R5 second operand", ciph_din, exp_in); end
          default: begin exp_in = ref_s ^ ref_r; chk(ciph_din == exp_in, "R6 third operand", ciph_din, exp_in); end
        endcase
        cnt = lat;
      end
      due2 = due1;
      due1 = dn && (call_idx < 3);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !reported) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      report();
    end
  end

  task automatic gen_now(input logic [W-1:0] t);
    gen_req = 1; tstamp = t;
    @(negedge clk); #1;
    gen_req = 0;
  endtask

  task automatic pulse_gen(input logic [W-1:0] t);
    @(negedge clk); #1;
    gen_now(t);
  endtask

  task automatic load_seed(input logic [W-1:0] v);
    @(negedge clk); #1;
    seed_load = 1; seed_in = v;
    @(negedge clk); #1;
    seed_load = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && ref_busy; k++) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    chk(rnd_valid == 0, "R1 valid low after reset", W'(rnd_valid), '0);
    chk(ciph_start == 0, "R1 start low after reset", W'(ciph_start), '0);

    pulse_gen(64'h1111);
    repeat (6) @(negedge clk); #1;
    chk(starts_seen == 0, "R2 no call before seed", W'(starts_seen), '0);

    load_seed(64'hDEAD_BEEF_CAFE_0001);
    pulse_gen(64'h0000_0000_0000_1000);
    wait_idle();
    chk(valids_seen == 1, "R4 first value produced", W'(valids_seen), W'(1));
    pulse_gen(64'h0000_0000_0000_2000);
    wait_idle();
    chk(valids_seen == 2, "R6 chained value produced", W'(valids_seen), W'(2));

    lat = 3;
    pulse_gen(64'h0000_0000_0000_3000);
    repeat (2) @(negedge clk); #1;
    gen_now(64'hFFFF_0000_FFFF_0000);
    load_seed(64'h0BAD_0BAD_0BAD_0BAD);
    wait_idle();
    chk(valids_seen == 3, "R10 strobes during run ignored", W'(valids_seen), W'(3));
    pulse_gen(64'h0000_0000_0000_4000);
    wait_idle();

    @(negedge clk); #1 spur = 1;
    @(negedge clk); #1 spur = 0;
    repeat (3) @(negedge clk); #1;
    chk(starts_seen == 12, "R11 stray done starts nothing", W'(starts_seen), W'(12));
    chk(valids_seen == 4, "R11 stray done gives no value", W'(valids_seen), W'(4));
    pulse_gen(64'h0000_0000_0000_5000);
    wait_idle();

    @(negedge clk); #1;
    seed_load = 1; seed_in = 64'h1234_5678_9ABC_DEF0;
    gen_req = 1; tstamp = 64'h7777;
    @(negedge clk); #1;
    seed_load = 0; gen_req = 0;
    repeat (4) @(negedge clk); #1;
    chk(starts_seen == 15, "R3 seed write beats request", W'(starts_seen), W'(15));
    pulse_gen(64'h0000_0000_0000_6000);

    lat = 1;
    wait_idle();
    gen_now(64'h0000_0000_0000_7000);
    wait_idle();
    chk(valids_seen == 7, "R9 back-to-back value count", W'(valids_seen), W'(7));

    repeat (3) @(negedge clk);
    report();
  end
endmodule